// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a slow word-wide main-memory port. It keeps 256 lines of 16 bytes each, 4 KB of data in total. Each line has a valid flag, a modified (dirty) flag and a 20-bit tag. A lookup compares the tag in the same cycle the request is presented. On a hit the access completes at the next clock edge with no stall. On a miss the processor is held off while the line is replaced.

Replacement depends on the state of the line being displaced. If that line holds modified data, its four words are first copied out to memory, at an address rebuilt from the stored tag and the index. The wanted block is then read in. If the displaced line is clean or empty, only the read-in takes place. Stores use write-allocate: a store that misses first brings its block in, then merges its bytes into the line and marks the line modified. Memory is written only when modified lines are displaced.

The processor must hold its request, address, byte enables and write data steady while the stall output is high.

Top module: `wb_dcache`

## Requirements
- R1: A 32-bit byte address splits as follows: bits [31:12] are the tag, bits [11:4] index one of 256 lines, bits [3:2] pick the word within the line and bits [1:0] pick the byte within the word.
- R2: Synchronous active-high reset clears every valid flag and every dirty flag, so the first access to any line after reset is a miss.
- R3: An access hits when the indexed line is valid and its stored tag equals the address tag. A hit keeps cpu_stall low in the cycle the request is presented, returns the addressed word on cpu_rdata in that cycle, and makes no memory transfer.
- R4: A miss reads the whole 16-byte aligned block from memory as four word reads in ascending address order, starting at the block base. It then marks the line valid with the new tag and returns the requested word.
- R5: A store hit merges only the bytes whose cpu_be bit is set into the line and marks the line dirty. Bit i of cpu_be enables bits [8i+7:8i] of the word (little-endian). Main memory is not written at that time.
- R6: A miss on a line that is valid and dirty first writes the four words of that line to memory, in ascending order from address {stored tag, index, 4'b0000}. Only after these writes does it begin the four refill reads.
- R7: A miss that displaces a valid clean line makes no memory write.
- R8: A store miss refills the line first, then applies the byte-enabled store and leaves the line dirty. A load refill leaves the line clean.
- R9: cpu_stall is high from the cycle a miss is detected until the cycle the requested access completes. Each memory transfer holds mem_req, mem_we, mem_addr and mem_wdata steady until a cycle in which mem_ack is high, and one word moves per such cycle.
- R10: Memory latency may vary from transfer to transfer without changing the result of any access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_be | input | 4 | Byte enables for stores, bit i enables byte lane i |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the request is not stalled |
| cpu_stall | output | 1 | High while the current request cannot complete |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current memory transfer |

## Verification
The hardest case to reach from the ports is a miss that displaces a dirty line. To get there, the bench must first fill a line, then modify it with a partial-byte store, and only then touch a different tag at the same index. It must also confirm that the modified bytes reach memory only at that moment. The bench sweeps all 256 indices through phases: cold fills, hits, byte-enabled stores, conflicting loads that force dirty and clean evictions, store misses, and a final pass that reads the original tags back. A reference model of valid, dirty and tag state in the bench predicts, for every access, the exact sequence of memory transfers. The memory responder changes its latency from one transfer to the next.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
package dcache_pkg;
  typedef enum logic [1:0] {
    DC_IDLE = 2'd0,
    DC_WB   = 2'd1,
    DC_FILL = 2'd2
  } dc_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
`timescale 1ns/1ps
module dcache_tag_store #(
  parameter int LINES = 256,
  parameter int IDX_W = 8,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             line_valid,
  output logic             line_dirty,
  output logic [TAG_W-1:0] line_tag,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_set,
  input  logic             dirty_clr
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // flags need reset, so they live in flops
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end
      if (dirty_set) dirty_q[idx] <= 1'b1;
      if (dirty_clr) dirty_q[idx] <= 1'b0;
    end
  end

  // tags need no reset, so they can map onto RAM
  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[idx] <= fill_tag;
  end

  assign line_valid = valid_q[idx];
  assign line_dirty = dirty_q[idx];
  assign line_tag   = tag_mem[idx];

  // R8
  flag_update_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fill_en && (dirty_set || dirty_clr)));
endmodule

// File: rtl/dcache_data_store.sv
`timescale 1ns/1ps
module dcache_data_store #(
  parameter int LINES  = 256,
  parameter int IDX_W  = 8,
  parameter int WSEL_W = 2,
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic [IDX_W-1:0]    idx,
  input  logic [WSEL_W-1:0]   rd_wsel,
  output logic [WORD_W-1:0]   rd_word,
  input  logic                wr_en,
  input  logic [WSEL_W-1:0]   wr_wsel,
  input  logic [WORD_W/8-1:0] wr_be,
  input  logic [WORD_W-1:0]   wr_data
);
  localparam int LANES = WORD_W / 8;
  localparam int DEPTH = LINES << WSEL_W;
  localparam int AW    = IDX_W + WSEL_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_addr;
  logic [AW-1:0]     wr_addr;

  assign rd_addr = {idx, rd_wsel};
  assign wr_addr = {idx, wr_wsel};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < LANES; b++) begin
        if (wr_be[b]) mem[wr_addr][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/dcache_ctrl.sv
`timescale 1ns/1ps
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int OFS_W  = 4,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 20,
  parameter int WSEL_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [WORD_W/8-1:0] cpu_be,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0]   cpu_wdata,
  output logic                cpu_stall,
  output logic [IDX_W-1:0]    line_idx,
  input  logic                line_valid,
  input  logic                line_dirty,
  input  logic [TAG_W-1:0]    line_tag,
  output logic                fill_en,
  output logic [TAG_W-1:0]    fill_tag,
  output logic                dirty_set,
  output logic                dirty_clr,
  output logic [WSEL_W-1:0]   rd_wsel,
  input  logic [WORD_W-1:0]   rd_word,
  output logic                wr_en,
  output logic [WSEL_W-1:0]   wr_wsel,
  output logic [WORD_W/8-1:0] wr_be,
  output logic [WORD_W-1:0]   wr_data,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                mem_ack
);
  localparam int BSEL_W = $clog2(WORD_W / 8);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
  localparam logic [WSEL_W-1:0] LAST_W = '1;

  dc_state_e           state_q;
  logic [WSEL_W-1:0]   cnt_q;
  logic                mem_req_q;
  logic                mem_we_q;
  logic [ADDR_W-1:0]   mem_addr_q;
  logic [WORD_W-1:0]   mem_wdata_q;

  logic [TAG_W-1:0]    a_tag;
  logic [WSEL_W-1:0]   a_wsel;
  logic                in_idle;
  logic                hit;
  logic                miss;
  logic                victim;
  logic                xfer;
  logic                last;
  logic [ADDR_W-1:0]   line_base;
  logic [ADDR_W-1:0]   victim_base;
  logic [BSEL_W-1:0]   unused_byte_sel;

  // R1 address split
  assign a_tag           = cpu_addr[ADDR_W-1 -: TAG_W];
  assign line_idx        = cpu_addr[OFS_W +: IDX_W];
  assign a_wsel          = cpu_addr[BSEL_W +: WSEL_W];
  assign unused_byte_sel = cpu_addr[BSEL_W-1:0];

  assign in_idle = (state_q == DC_IDLE);
  assign hit     = in_idle && cpu_req && line_valid && (line_tag == a_tag);
  assign miss    = in_idle && cpu_req && !hit;
  assign victim  = line_valid && line_dirty;
  assign xfer    = mem_req_q && mem_ack;
  assign last    = (cnt_q == LAST_W);

  assign line_base   = {a_tag, line_idx, {OFS_W{1'b0}}};
  assign victim_base = {line_tag, line_idx, {OFS_W{1'b0}}};

  assign cpu_stall = cpu_req && !hit;

  // read port: requested word on a lookup, word 0 when a write-back starts,
  // the following word while a write-back is running
  always_comb begin
    if (in_idle) rd_wsel = miss ? '0 : a_wsel;
    else         rd_wsel = cnt_q + 1'b1;
  end

  // write port: store hits merge bytes, refill beats write full words
  assign wr_en   = (hit && cpu_we) || ((state_q == DC_FILL) && xfer);
  assign wr_wsel = in_idle ? a_wsel : cnt_q;
  assign wr_be   = in_idle ? cpu_be : '1;
  assign wr_data = in_idle ? cpu_wdata : mem_rdata;

  assign fill_en   = (state_q == DC_FILL) && xfer && last;
  assign fill_tag  = a_tag;
  assign dirty_set = hit && cpu_we;
  assign dirty_clr = (state_q == DC_WB) && xfer && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= DC_IDLE;
      cnt_q       <= '0;
      mem_req_q   <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      case (state_q)
        DC_IDLE: begin
          if (miss) begin
            cnt_q     <= '0;
            mem_req_q <= 1'b1;
            if (victim) begin
              state_q     <= DC_WB;
              mem_we_q    <= 1'b1;
              mem_addr_q  <= victim_base;
              mem_wdata_q <= rd_word;
            end else begin
              state_q    <= DC_FILL;
              mem_we_q   <= 1'b0;
              mem_addr_q <= line_base;
            end
          end
        end
        DC_WB: begin
          if (xfer) begin
            if (last) begin
              state_q    <= DC_FILL;
              cnt_q      <= '0;
              mem_we_q   <= 1'b0;
              mem_addr_q <= line_base;
            end else begin
              cnt_q       <= cnt_q + 1'b1;
              mem_addr_q  <= mem_addr_q + STEP;
              mem_wdata_q <= rd_word;
            end
          end
        end
        DC_FILL: begin
          if (xfer) begin
            if (last) begin
              state_q   <= DC_IDLE;
              cnt_q     <= '0;
              mem_req_q <= 1'b0;
            end else begin
              cnt_q      <= cnt_q + 1'b1;
              mem_addr_q <= mem_addr_q + STEP;
            end
          end
        end
        default: state_q <= DC_IDLE;
      endcase
    end
  end

  assign mem_req   = mem_req_q;
  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_q && !mem_ack |=> mem_req_q && $stable(mem_addr_q)
      && $stable(mem_we_q) && $stable(mem_wdata_q));

  // R9
  stall_during_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_q && cpu_req |-> cpu_stall);

  // R4
  block_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_q) |-> (mem_addr_q[OFS_W-1:0] == '0));

  // R4
  ascending_chk: assert property (@(posedge clk) disable iff (rst)
    xfer && !last |=> mem_addr_q == $past(mem_addr_q) + STEP);

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
    xfer && mem_we_q && last |=> mem_req_q && !mem_we_q);

  // R6
  fill_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == DC_FILL) |-> !mem_we_q);
endmodule

// File: rtl/wb_dcache.sv
`timescale 1ns/1ps
module wb_dcache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int LINES      = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [WORD_W/8-1:0] cpu_be,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [WORD_W-1:0]   cpu_wdata,
  output logic [WORD_W-1:0]   cpu_rdata,
  output logic                cpu_stall,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata,
  input  logic [WORD_W-1:0]   mem_rdata,
  input  logic                mem_ack
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFS_W;
  localparam int WSEL_W = $clog2(LINE_BYTES / (WORD_W / 8));
  localparam int BE_W   = WORD_W / 8;

  logic [IDX_W-1:0]  line_idx;
  logic              line_valid;
  logic              line_dirty;
  logic [TAG_W-1:0]  line_tag;
  logic              fill_en;
  logic [TAG_W-1:0]  fill_tag;
  logic              dirty_set;
  logic              dirty_clr;
  logic [WSEL_W-1:0] rd_wsel;
  logic [WORD_W-1:0] rd_word;
  logic              wr_en;
  logic [WSEL_W-1:0] wr_wsel;
  logic [BE_W-1:0]   wr_be;
  logic [WORD_W-1:0] wr_data;

  dcache_tag_store #(
    .LINES (LINES),
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk        (clk),
    .rst        (rst),
    .idx        (line_idx),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag),
    .fill_en    (fill_en),
    .fill_tag   (fill_tag),
    .dirty_set  (dirty_set),
    .dirty_clr  (dirty_clr)
  );

  dcache_data_store #(
    .LINES  (LINES),
    .IDX_W  (IDX_W),
    .WSEL_W (WSEL_W),
    .WORD_W (WORD_W)
  ) u_data (
    .clk     (clk),
    .idx     (line_idx),
    .rd_wsel (rd_wsel),
    .rd_word (rd_word),
    .wr_en   (wr_en),
    .wr_wsel (wr_wsel),
    .wr_be   (wr_be),
    .wr_data (wr_data)
  );

  dcache_ctrl #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .OFS_W  (OFS_W),
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .WSEL_W (WSEL_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_be     (cpu_be),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_stall  (cpu_stall),
    .line_idx   (line_idx),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag),
    .fill_en    (fill_en),
    .fill_tag   (fill_tag),
    .dirty_set  (dirty_set),
    .dirty_clr  (dirty_clr),
    .rd_wsel    (rd_wsel),
    .rd_word    (rd_word),
    .wr_en      (wr_en),
    .wr_wsel    (wr_wsel),
    .wr_be      (wr_be),
    .wr_data    (wr_data),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack)
  );

  assign cpu_rdata = rd_word;
endmodule

// File: tb/wb_dcache_bench.sv
`timescale 1ns/1ps
module wb_dcache_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req, cpu_we;
  logic [3:0]  cpu_be;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_ack;

  always #2.5 clk = ~clk;

  wb_dcache u_wb_dcache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem_q [logic [31:0]];
  logic [31:0] exp_q [logic [31:0]];
  logic [31:0] log_addr [16];
  bit          log_we [16];
  int          log_n;
  int          wait_cnt;
  int          nx;

  bit          bvalid [256];
  bit          bdirty [256];
  logic [19:0] btag [256];

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_q.exists(a) ? mem_q[a] : init_val(a);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] a);
    return exp_q.exists(a) ? exp_q[a] : init_val(a);
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory responder: latency cycles 0..4 change per transfer (R10)
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; wait_cnt = 0; nx = 0; log_n = 0;
    forever begin
      @(negedge clk);
      if (rst || mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (wait_cnt >= (nx * 3) % 5) begin
          if (log_n < 16) begin
            log_addr[log_n] = mem_addr;
            log_we[log_n]   = mem_we;
          end
          log_n++;
          if (mem_we) mem_q[mem_addr] = mem_wdata;
          else        mem_rdata = mem_rd(mem_addr);
          mem_ack  = 1'b1;
          wait_cnt = 0;
          nx++;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [3:0] be, input logic [31:0] addr,
                        input logic [31:0] wd, input string rq);
    int          idx;
    logic [19:0] tg;
    bit          hit;
    bit          ev;
    int          n_exp;
    int          stalls;
    string       xr;
    logic [31:0] rd;
    logic [31:0] vbase;
    logic [31:0] nbase;
    logic [31:0] wa;
    logic [31:0] ea;
    bit          ew;
    logic [31:0] merged;
    idx   = int'(addr[11:4]);
    tg    = addr[31:12];
    wa    = {addr[31:2], 2'b00};
    hit   = bvalid[idx] && (btag[idx] == tg);
    ev    = !hit && bvalid[idx] && bdirty[idx];
    vbase = {btag[idx], addr[11:4], 4'h0};
    nbase = {addr[31:4], 4'h0};
    n_exp = hit ? 0 : (ev ? 8 : 4);
    xr    = hit ? "R3" : (ev ? "R6" : (bvalid[idx] ? "R7" : "R4"));
    @(negedge clk);
    log_n = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_be = be; cpu_addr = addr; cpu_wdata = wd;
    stalls = 0;
    #1;
    while (cpu_stall && stalls < 4000) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (hit) chk(stalls == 0, "R3", 32'(stalls), 32'd0);
    else     chk(stalls > 0,  "R9", 32'(stalls), 32'd1);
    chk(log_n == n_exp, xr, 32'(log_n), 32'(n_exp));
    for (int k = 0; k < n_exp && k < log_n && k < 16; k++) begin
      if (ev && k < 4) begin ea = vbase + 32'(4 * k);     ew = 1'b1; end
      else if (ev)     begin ea = nbase + 32'(4 * (k - 4)); ew = 1'b0; end
      else             begin ea = nbase + 32'(4 * k);     ew = 1'b0; end
      chk(log_addr[k] == ea && log_we[k] == ew, xr, log_addr[k], ea);
    end
    if (!hit) begin
      bvalid[idx] = 1'b1; btag[idx] = tg; bdirty[idx] = 1'b0;
    end
    if (we) begin
      merged = exp_rd(wa);
      for (int b = 0; b < 4; b++) if (be[b]) merged[8*b +: 8] = wd[8*b +: 8];
      exp_q[wa]   = merged;
      bdirty[idx] = 1'b1;
    end else begin
      chk(rd == exp_rd(wa), rq, rd, exp_rd(wa));
    end
  endtask

  localparam logic [19:0] T0 = 20'h10010;
  localparam logic [19:0] T1 = 20'h25371;
  localparam logic [19:0] T2 = 20'h7FFFE;

  function automatic logic [31:0] mk(input logic [19:0] t, input int i, input int w);
    return {t, 8'(i), 2'(w), 2'b00};
  endfunction

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin bvalid[i] = 0; bdirty[i] = 0; btag[i] = '0; end
    rst = 1'b1; cpu_req = 0; cpu_we = 0; cpu_be = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R2 reset state at the ports
    chk(cpu_stall == 1'b0, "R2", 32'(cpu_stall), 32'd0);
    chk(mem_req == 1'b0, "R2", 32'(mem_req), 32'd0);

    // cold fills after reset: every index misses (R2, R4, R10)
    for (int i = 0; i < 256; i++) access(0, 4'h0, mk(T0, i, i % 4), 32'h0, "R2");
    // other words of the same lines hit (R1, R3)
    for (int i = 0; i < 256; i++) access(0, 4'h0, mk(T0, i, (i + 1) % 4), 32'h0, "R1");
    // byte-enabled store hits on even lines, memory untouched (R5)
    for (int i = 0; i < 256; i += 2) begin
      access(1, 4'(((i >> 1) % 15) + 1), mk(T0, i, i % 4), 32'hA5000000 | 32'(i), "R5");
      chk(mem_rd(mk(T0, i, i % 4)) == init_val(mk(T0, i, i % 4)), "R5",
          mem_rd(mk(T0, i, i % 4)), init_val(mk(T0, i, i % 4)));
      access(0, 4'h0, mk(T0, i, i % 4), 32'h0, "R5");
    end
    // conflicting tag: dirty lines write back, clean lines do not (R6, R7, R10)
    for (int i = 0; i < 256; i++) access(0, 4'h0, mk(T1, i, 3 - (i % 4)), 32'h0, "R10");
    // store misses allocate then merge (R8)
    for (int i = 1; i < 256; i += 4) begin
      access(1, 4'hF, mk(T2, i, 2), 32'h5EED0000 | 32'(i), "R8");
      access(0, 4'h0, mk(T2, i, 2), 32'h0, "R8");
      access(0, 4'h0, mk(T2, i, 1), 32'h0, "R8");
    end
    // reading the first tag back shows written-back data (R6)
    for (int i = 0; i < 256; i++) access(0, 4'h0, mk(T0, i, i % 4), 32'h0, "R6");
    // every modified word has reached memory after its eviction (R6)
    foreach (exp_q[k]) chk(mem_rd(k) == exp_q[k], "R6", mem_rd(k), exp_q[k]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule